// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master with 8-bit frames, controlled over a simple 32-bit register port. Software configures clock polarity, clock phase, bit order and an internal loopback path through a control word, and drives the active-low chip-select lines directly through a select register. It queues outgoing bytes in a 16-entry transmit FIFO and collects incoming bytes in a 16-entry receive FIFO. A status word reports whether each FIFO is empty or full. Occupancy registers report each FIFO's fill level. A keyed write to the reset register returns the whole block to its power-up state.

A typical sequence is as follows. Software writes the control word, clears one bit of the select register to choose a slave, and writes bytes to the transmit data register. It then polls the receive-empty status bit and reads the same number of bytes back. Every byte shifted out captures exactly one byte from the serial input.

The shift engine is a three-state machine. `SH_IDLE` holds SCLK at its idle level. `SH_IDLE -> SH_LEAD` fires when the enable gate is open, the transmit FIFO holds a byte and the receive FIFO has room, and it pops one byte. `SH_LEAD -> SH_TRAIL` fires after a half period and samples the serial input. `SH_TRAIL -> SH_LEAD` fires after a half period and advances to the next bit. `SH_TRAIL -> SH_IDLE` fires after the eighth bit and pushes the received byte.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the registers read as follows: control (byte 0x60) reads 0x180, status (0x64) reads 0x25, and select (0x70) reads all ones. SCLK is low and every chip-select output is high.
- R2: Writing exactly 0x0A to the reset register (0x40) returns every register and both FIFOs to the R1 state. Writing any other value there changes nothing.
- R3: A write to the transmit data register (0x68) sends only bits 7:0. A read of the receive data register (0x6C) returns the byte in bits 7:0 with the upper bits zero, and removes that byte from the receive FIFO.
- R4: A byte starts shifting only while control bit 1 (enable) and bit 2 (master) are set and bit 8 (inhibit) is clear. Otherwise written bytes stay queued and SCLK does not toggle.
- R5: The chip-select outputs equal the select register at all times. Writing all ones deselects every slave, and a zero in bit n selects slave n.
- R6: Each FIFO holds 16 bytes. Status bit 3 (transmit full) and bit 1 (receive full) flag 16 entries. Writes to a full transmit FIFO are dropped. The occupancy registers (0x74 transmit, 0x78 receive) read the entry count minus one in bits 3:0.
- R7: Status bit 0 (receive empty) stays set until the whole captured byte is in the receive FIFO. No byte starts while the receive FIFO is full, so no captured byte is ever lost.
- R8: With control bit 0 set, the serial output feeds the receive side in place of MISO.
- R9: Control bit 3 (CPOL) sets the SCLK idle level. With control bit 4 (CPHA) clear, data is sampled on the first SCLK edge of each bit; with it set, on the second edge. Bytes go out MSB first, or LSB first with control bit 9 set, and received bytes are assembled in the same order.
- R10: Writing control bit 5 empties the transmit FIFO and writing bit 6 empties the receive FIFO. Both bits read back as zero.
- R11: The interrupt registers (0x1C, 0x20, 0x28) read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on receive-data reads) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NSS | Active-low chip selects |

## Verification
Several internal faults show up at the ports. A stuck shift state shows as SCLK frozen at or away from its idle level, or as receive-empty never clearing within one frame time (about 33 cycles per byte). A wrong bit counter or sample point shows as a corrupted byte at the slave model or at the receive data register, at the end of that same frame. FIFO pointer or count errors appear in the occupancy and full/empty status bits at the next register read. They also appear as out-of-order or missing bytes when a run of 16 or 17 bytes is drained. A gate that ignores inhibit or receive-full shows as extra SCLK edges or a transmit FIFO that empties too early.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {SH_IDLE, SH_LEAD, SH_TRAIL} sh_state_t;

    // register byte addresses
    localparam logic [7:0] A_GIE   = 8'h1C;
    localparam logic [7:0] A_ISR   = 8'h20;
    localparam logic [7:0] A_IER   = 8'h28;
    localparam logic [7:0] A_RST   = 8'h40;
    localparam logic [7:0] A_CTRL  = 8'h60;
    localparam logic [7:0] A_STAT  = 8'h64;
    localparam logic [7:0] A_TXD   = 8'h68;
    localparam logic [7:0] A_RXD   = 8'h6C;
    localparam logic [7:0] A_SEL   = 8'h70;
    localparam logic [7:0] A_TXOCC = 8'h74;
    localparam logic [7:0] A_RXOCC = 8'h78;

    localparam logic [31:0] RST_KEY = 32'h0000_000A;

    // control bit positions
    localparam int C_LOOP = 0;
    localparam int C_EN   = 1;
    localparam int C_MST  = 2;
    localparam int C_CPOL = 3;
    localparam int C_CPHA = 4;
    localparam int C_TXCL = 5;
    localparam int C_RXCL = 6;
    localparam int C_INH  = 8;
    localparam int C_LSB  = 9;

    localparam logic [9:0] CTRL_DFLT = 10'h180;
    localparam logic [9:0] CTRL_KEEP = 10'h39F;

    function automatic logic [BYTE_W-1:0] rev_bits(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [AW:0]      count
);
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             do_push, do_pop;

    assign do_push = push && (count != FULL);
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; count <= '0;
        end else if (clr) begin
            wp <= '0; rp <= '0; count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);
    assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL && push && !pop && !clr) |=> count == FULL);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int HALF_DIV = 2,
    localparam int CW = $clog2(HALF_DIV + 1),
    localparam int BW = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              go,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              loop,
    input  logic              tx_avail,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_pop,
    input  logic              rx_room,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_push,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    sh_state_t         state, nxt;
    logic [CW-1:0]     div_cnt;
    logic [BW-1:0]     bit_cnt;
    logic [BYTE_W-1:0] tx_sh, rx_sh;
    logic              half_end, last_bit, din;

    assign half_end = (div_cnt == CW'(HALF_DIV - 1));
    assign last_bit = (bit_cnt == BW'(BYTE_W - 1));
    assign din      = loop ? mosi : miso;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            SH_IDLE:  if (go && tx_avail && rx_room) nxt = SH_LEAD;
            SH_LEAD:  if (half_end) nxt = SH_TRAIL;
            SH_TRAIL: if (half_end) nxt = last_bit ? SH_IDLE : SH_LEAD;
            default:  nxt = SH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_pop  = (state == SH_IDLE) && (nxt == SH_LEAD);
        rx_push = (state == SH_TRAIL) && half_end && last_bit;
        busy    = (state != SH_IDLE);
        mosi    = tx_sh[BYTE_W-1];
        rx_byte = lsb_first ? rev_bits(rx_sh) : rx_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_IDLE; div_cnt <= '0; bit_cnt <= '0;
            tx_sh <= '0; rx_sh <= '0; sclk <= 1'b0;
        end else if (clr) begin
            state <= SH_IDLE; div_cnt <= '0; bit_cnt <= '0;
            tx_sh <= '0; rx_sh <= '0; sclk <= 1'b0;
        end else begin
            state <= nxt;
            sclk  <= cpol ^ (cpha ? (nxt == SH_LEAD) : (nxt == SH_TRAIL));
            div_cnt <= (state == SH_IDLE || half_end) ? '0 : div_cnt + 1'b1;
            if (tx_pop) begin
                tx_sh   <= lsb_first ? rev_bits(tx_byte) : tx_byte;
                bit_cnt <= '0;
            end
            if (state == SH_LEAD && half_end) rx_sh <= {rx_sh[BYTE_W-2:0], din};
            if (state == SH_TRAIL && half_end) begin
                tx_sh   <= tx_sh << 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_IDLE && $past(state) == SH_IDLE && $stable(cpol) && !$past(clr))
            |-> sclk == cpol);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int NSS      = 8,
    parameter int DEPTH    = 16,
    parameter int HALF_DIV = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           spi_sclk,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [NSS-1:0] spi_ss_n
);
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    logic [9:0]        ctrl_q;
    logic [NSS-1:0]    sel_q;
    logic              srst, wr_ctrl, wr_tx, wr_sel, rd_rx, go;
    logic [AW:0]       tx_cnt, rx_cnt;
    logic [BYTE_W-1:0] tx_head, rx_head, rx_new;
    logic              tx_pop, rx_push, busy;
    logic [AW-1:0]     tx_occ, rx_occ;
    logic [5:0]        stat;

    assign srst    = bus_wr && bus_addr == A_RST && bus_wdata == RST_KEY;
    assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
    assign wr_tx   = bus_wr && bus_addr == A_TXD;
    assign wr_sel  = bus_wr && bus_addr == A_SEL;
    assign rd_rx   = bus_rd && bus_addr == A_RXD;
    assign go      = ctrl_q[C_EN] && ctrl_q[C_MST] && !ctrl_q[C_INH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_DFLT;
            sel_q  <= '1;
        end else if (srst) begin
            ctrl_q <= CTRL_DFLT;
            sel_q  <= '1;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[9:0] & CTRL_KEEP;
            if (wr_sel)  sel_q  <= bus_wdata[NSS-1:0];
        end
    end

    assign spi_ss_n = sel_q;

    spim_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .clr(srst || (wr_ctrl && bus_wdata[C_TXCL])),
        .push(wr_tx), .din(bus_wdata[BYTE_W-1:0]),
        .pop(tx_pop), .dout(tx_head), .count(tx_cnt));

    spim_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .clr(srst || (wr_ctrl && bus_wdata[C_RXCL])),
        .push(rx_push), .din(rx_new),
        .pop(rd_rx), .dout(rx_head), .count(rx_cnt));

    spim_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(srst), .go(go),
        .cpol(ctrl_q[C_CPOL]), .cpha(ctrl_q[C_CPHA]),
        .lsb_first(ctrl_q[C_LSB]), .loop(ctrl_q[C_LOOP]),
        .tx_avail(tx_cnt != '0), .tx_byte(tx_head), .tx_pop(tx_pop),
        .rx_room(rx_cnt != FULL), .rx_byte(rx_new), .rx_push(rx_push),
        .busy(busy), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso));

    assign tx_occ = AW'(tx_cnt - 1'b1);
    assign rx_occ = AW'(rx_cnt - 1'b1);
    assign stat   = {1'b1, 1'b0, tx_cnt == FULL, tx_cnt == '0,
                     rx_cnt == FULL, rx_cnt == '0};

    always_comb begin
        case (bus_addr)
            A_GIE, A_ISR, A_IER: bus_rdata = '0;
            A_CTRL:  bus_rdata = 32'(ctrl_q);
            A_STAT:  bus_rdata = 32'(stat);
            A_RXD:   bus_rdata = (rx_cnt != '0) ? 32'(rx_head) : '0;
            A_SEL:   bus_rdata = 32'(sel_q);
            A_TXOCC: bus_rdata = 32'(tx_occ);
            A_RXOCC: bus_rdata = 32'(rx_occ);
            default: bus_rdata = '0;
        endcase
    end

    assert_inhibit_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !busy) |=> !busy);
    assert_rx_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> rx_cnt != FULL);
    assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_sel || srst) |=> $stable(spi_ss_n));
endmodule

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi;
    logic        miso_q = 1'b0;
    logic [7:0]  spi_ss_n;

    int nchk = 0, nerr = 0, sclk_edges = 0;
    bit done = 0;

    // slave model
    logic       slv_arm = 1'b0, b_cpol = 1'b0, b_cpha = 1'b0;
    logic [7:0] slv_out = '0, slv_cap = '0;
    int         slv_k = 0;

    spim_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(miso_q),
        .spi_ss_n(spi_ss_n));

    always #5 clk = ~clk;

    always @(spi_sclk) begin
        sclk_edges++;
        if (slv_arm) begin
            if ((spi_sclk != b_cpol) != b_cpha) begin
                slv_cap = {slv_cap[6:0], spi_mosi};
                slv_k++;
                if (slv_k < 8) miso_q = slv_out[7-slv_k];
            end
        end
    end

    function automatic logic [7:0] rv(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h60, v); check("R1 ctrl", v, 32'h180);
        rd(8'h64, v); check("R1 status", v, 32'h25);
        rd(8'h70, v); check("R1 select", v, 32'hFF);
        check("R1 pins", {spi_sclk, spi_ss_n}, {1'b0, 8'hFF});
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, v); check("R11 ier", v, 0);
        rd(8'h1C, v); check("R11 gie", v, 0);
        rd(8'h20, v); check("R11 isr", v, 0);
    endtask

    task automatic t_xfer(input bit cpol, input bit cpha, input bit lsb,
                          input logic [7:0] tx, input logic [7:0] so);
        logic [31:0] v;
        int n;
        b_cpol = cpol; b_cpha = cpha;
        wr(8'h60, 32'h086 | (32'(cpol) << 3) | (32'(cpha) << 4) | (32'(lsb) << 9));
        waitc(2);
        check("R9 idle level", 32'(spi_sclk), 32'(cpol));
        slv_out = so; slv_cap = '0; slv_k = 0; miso_q = so[7]; slv_arm = 1'b1;
        wr(8'h70, 32'hFE);
        check("R5 select", 32'(spi_ss_n), 32'hFE);
        wr(8'h68, {24'hABCDEF, tx});
        rd(8'h64, v); check("R7 rx empty during frame", 32'(v[0]), 1);
        n = 0;
        do begin rd(8'h64, v); n++; end while (v[0] && n < 100);
        rd(8'h6C, v);
        check("R3/R9 rx byte", v, 32'(lsb ? rv(so) : so));
        check("R3/R9 mosi byte", 32'(slv_cap), 32'(lsb ? rv(tx) : tx));
        check("R9 bit count", slv_k, 8);
        slv_arm = 1'b0;
        wr(8'h70, 32'hFF);
        check("R5 deselect", 32'(spi_ss_n), 32'hFF);
    endtask

    task automatic t_inhibit();
        logic [31:0] v;
        int e0;
        b_cpol = 1'b0;
        wr(8'h60, 32'h186);
        waitc(2);
        e0 = sclk_edges;
        for (int i = 0; i < 3; i++) wr(8'h68, 32'h30 + 32'(i));
        waitc(100);
        check("R4 no sclk while inhibited", sclk_edges, e0);
        rd(8'h74, v); check("R4/R6 tx occupancy", v, 2);
        rd(8'h64, v); check("R4 status queued", v, 32'h21);
        wr(8'h60, 32'h086);
        waitc(150);
        rd(8'h64, v); check("R4 status drained", v, 32'h24);
        rd(8'h78, v); check("R6 rx occupancy", v, 2);
        wr(8'h60, 32'h0C6);
        rd(8'h60, v); check("R10 rx clear reads zero", v, 32'h086);
        rd(8'h64, v); check("R10 rx cleared", v, 32'h25);
    endtask

    task automatic t_full();
        logic [31:0] v;
        miso_q = 1'b0;
        wr(8'h60, 32'h187);
        for (int i = 0; i < 17; i++) wr(8'h68, (i == 16) ? 32'hEE : 32'h10 + 32'(i));
        rd(8'h64, v); check("R6 tx full", 32'(v[3]), 1);
        rd(8'h74, v); check("R6 tx occupancy full", v, 32'hF);
        wr(8'h60, 32'h087);
        waitc(700);
        rd(8'h64, v); check("R6 rx full tx empty", v, 32'h26);
        rd(8'h78, v); check("R6 rx occupancy full", v, 32'hF);
        for (int i = 0; i < 16; i++) begin
            rd(8'h6C, v); check("R8 loopback byte", v, 32'h10 + 32'(i));
        end
        rd(8'h64, v); check("R6 overflow byte dropped", v, 32'h25);
        for (int i = 0; i < 17; i++) wr(8'h68, 32'h40 + 32'(i));
        waitc(700);
        rd(8'h64, v); check("R7 rx full blocks start", 32'(v[2:1]), 32'b01);
        rd(8'h6C, v); check("R7 first byte", v, 32'h40);
        waitc(80);
        rd(8'h74, v); rd(8'h64, v); check("R7 last byte sent", 32'(v[2:1]), 32'b11);
        for (int i = 1; i < 17; i++) begin
            rd(8'h6C, v); check("R7 byte order", v, 32'h40 + 32'(i));
        end
        wr(8'h60, 32'h187);
        wr(8'h68, 32'h55);
        wr(8'h60, 32'h1A7);
        rd(8'h60, v); check("R10 tx clear reads zero", v, 32'h187);
        rd(8'h64, v); check("R10 tx cleared", v, 32'h25);
    endtask

    task automatic t_softreset();
        logic [31:0] v;
        wr(8'h60, 32'h08E);
        wr(8'h70, 32'h00);
        wr(8'h40, 32'h0B);
        rd(8'h60, v); check("R2 wrong key ignored", v, 32'h08E);
        check("R2 wrong key select", 32'(spi_ss_n), 0);
        wr(8'h40, 32'h0A);
        rd(8'h60, v); check("R2 ctrl default", v, 32'h180);
        rd(8'h64, v); check("R2 status default", v, 32'h25);
        check("R2 select default", 32'(spi_ss_n), 32'hFF);
        waitc(2);
        check("R2 sclk default", 32'(spi_sclk), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        waitc(3);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_xfer(0, 0, 0, 8'hA5, 8'h3C);
        t_xfer(1, 1, 0, 8'h96, 8'hC1);
        t_xfer(0, 1, 1, 8'h1E, 8'h82);
        t_xfer(1, 0, 1, 8'hF0, 8'h5B);
        t_inhibit();
        t_full();
        t_softreset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule